// File: doc/BRIEF.md
# Vector-to-Pin Interrupt Routing Controller

This block gathers up to 256 level-sensitive interrupt request lines. Each line is sampled on every clock into a pending bit. A pending bit that is also enabled counts as active. Vectors are handled in groups of 32, and each group owns one route byte. A route byte with exactly one bit set picks the CPU interrupt pin that the group drives. Each pin output is the registered OR of every active vector whose group picks that pin.

Software reaches the state through a small read/write port that uses byte addresses:

| Region | Base | Access | Layout |
|---|---|---|---|
| Enable words | 0x00 | 32-bit | Vector v sits in the word at 0x00 + (v>>5)*4, bit v & 31 |
| Route words | 0x40 | 32-bit | Byte b of the word at 0x40 + i*4 steers group 4i+b |
| Status words | 0x80 | 64-bit | The word at 0x80 + i*8 holds vectors 64i to 64i+63 |

Pending bits are cleared by writing 1 to them in a status word.

There are two common ways to program the route map. In the single-pin layout, every route byte is 0x01. In the multi-pin layout, the route words are 0x02020101 and 0x08080404. This gives each 64-vector status word its own consecutive pin, so an interrupt handler on one pin only needs to read one status word.

The read port is driven by a two-state machine, BUS_IDLE and BUS_RESP. A read request in either state moves to, or stays in, BUS_RESP, and the read data is captured at that same edge. A cycle with no read request returns the machine to BUS_IDLE. rd_valid_o is high exactly while the machine is in BUS_RESP.

Top module: `vec_pin_router`

## Requirements
- R1: After reset, all pending bits, enables and route bytes are zero, every pin output is low and rd_valid_o is low.
- R2: A high request line sets its pending bit at the next clock edge. The bit stays set after the line falls, until software clears it.
- R3: Writing a status word clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R4: If a request is high in the same cycle as a clear of that vector, the pending bit stays set.
- R5: The enable bit for vector v is bit v & 31 of the 32-bit word at byte address (v>>5)*4. A read returns that word zero-extended, and data bits 63:32 of a write are ignored.
- R6: Byte b (bits 8b+7:8b) of the route word at 0x40 + i*4 steers vectors 32(4i+b) to 32(4i+b)+31, and a read returns the word as written.
- R7: Pin n is high one cycle after some vector is both pending and enabled while its group's route byte is exactly 1<<n. Otherwise pin n is low.
- R8: A pending vector whose enable bit is 0 drives no pin.
- R9: A group whose route byte is zero or has more than one bit set drives no pin. Its vectors still latch and read back as pending.
- R10: The status word at 0x80 + i*8 returns pending bits 64i to 64i+63, with vector 64i in bit 0.
- R11: Read data appears on rdata_o with rd_valid_o high in the cycle after rd_en_i is sampled. Back-to-back reads return one word per cycle.
- R12: With route words 0x02020101 and 0x08080404, vectors 0-63, 64-127, 128-191 and 192-255 drive pins 0, 1, 2 and 3 respectively. With every route byte set to 0x01, all vectors drive pin 0.
- R13: Reads from addresses outside the three regions return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_VEC | Level request, one per vector |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 64 | Write data; only bits 31:0 are used for enable and route words |
| rdata_o | output | 64 | Read data, valid while rd_valid_o is high |
| rd_valid_o | output | 1 | Read response flag, high in BUS_RESP |
| pin_o | output | NUM_PIN | CPU interrupt pin outputs |

## Verification
The bench builds the block with NUM_VEC = 256 and NUM_PIN = 8. This gives the full address space: eight enable words, two route words and four status words. It also makes reachable both the highest vector (255) and the top pin codes used by the multi-pin layout. With the widest route byte in use, the invalid codes 0x00 and 0x03 can be written next to valid ones, and a request can meet its own clear in the same cycle. Back-to-back reads also exercise the BUS_RESP to BUS_RESP transition.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    localparam int GRP_W  = 32;
    localparam int STAT_W = 64;
    localparam int REG_W  = 32;
    localparam int CODE_W = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 64;

    localparam logic [ADDR_W-1:0] EN_BASE = 8'h00;
    localparam logic [ADDR_W-1:0] RT_BASE = 8'h40;
    localparam logic [ADDR_W-1:0] ST_BASE = 8'h80;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/irqr_vec_state.sv
module irqr_vec_state
    import irqr_pkg::*;
#(
    parameter int NUM_VEC = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_VEC-1:0]         irq_i,
    input  logic [NUM_VEC-1:0]         clr_i,
    input  logic [NUM_VEC/GRP_W-1:0]   en_we_i,
    input  logic [REG_W-1:0]           wdata_i,
    output logic [NUM_VEC-1:0]         pend_o,
    output logic [NUM_VEC-1:0]         en_o
);

    localparam int EN_WORDS = NUM_VEC / GRP_W;

    logic [NUM_VEC-1:0] pend_q;
    logic [REG_W-1:0]   en_q [EN_WORDS];

    // Request has priority over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | irq_i;
        end
    end

    for (genvar w = 0; w < EN_WORDS; w++) begin : g_en_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[w] <= '0;
            end else if (en_we_i[w]) begin
                en_q[w] <= wdata_i;
            end
        end
        assign en_o[w*GRP_W +: GRP_W] = en_q[w];
    end

    assign pend_o = pend_q;

    AST_REQ_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i != '0) |=> ((pend_q & $past(irq_i)) == $past(irq_i))); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((pend_q & $past(clr_i) & ~$past(irq_i)) == '0)); // R3

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(irq_i)) == '0)); // R2

endmodule

// File: rtl/irqr_pin_route.sv
module irqr_pin_route
    import irqr_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int NUM_PIN = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_VEC/(GRP_W*4)-1:0]     rt_we_i,
    input  logic [REG_W-1:0]                 wdata_i,
    input  logic [NUM_VEC-1:0]               pend_i,
    input  logic [NUM_VEC-1:0]               en_i,
    output logic [NUM_VEC/(GRP_W*4)*REG_W-1:0] route_o,
    output logic [NUM_PIN-1:0]               pin_o
);

    localparam int GROUPS   = NUM_VEC / GRP_W;
    localparam int RT_WORDS = GROUPS / 4;

    logic [REG_W-1:0]  rt_q [RT_WORDS];
    logic [CODE_W-1:0] grp_code [GROUPS];
    logic [GROUPS-1:0] grp_act;
    logic [GROUPS-1:0] grp_ok;
    logic [NUM_PIN-1:0] pin_d;
    logic [NUM_PIN-1:0] pin_q;

    for (genvar w = 0; w < RT_WORDS; w++) begin : g_rt_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rt_q[w] <= '0;
            end else if (rt_we_i[w]) begin
                rt_q[w] <= wdata_i;
            end
        end
        assign route_o[w*REG_W +: REG_W] = rt_q[w];
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        assign grp_code[g] = rt_q[g/4][(g%4)*CODE_W +: CODE_W];
        assign grp_act[g]  = |(pend_i[g*GRP_W +: GRP_W] & en_i[g*GRP_W +: GRP_W]);
        assign grp_ok[g]   = (grp_code[g] != '0) &&
                             ((grp_code[g] & (grp_code[g] - CODE_W'(1))) == '0);
    end

    always_comb begin
        pin_d = '0;
        for (int p = 0; p < NUM_PIN; p++) begin
            for (int g = 0; g < GROUPS; g++) begin
                if (grp_act[g] && grp_ok[g] && grp_code[g][p]) begin
                    pin_d[p] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign pin_o = pin_q;

    AST_PIN_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_q != '0) |-> ($past(pend_i & en_i) != '0)); // R7

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |=> (pin_q == '0)); // R8

    AST_BAD_ROUTE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_ok == '0) |=> (pin_q == '0)); // R9

endmodule

// File: rtl/irqr_reg_port.sv
module irqr_reg_port
    import irqr_pkg::*;
#(
    parameter int NUM_VEC = 256
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en_i,
    input  logic                               rd_en_i,
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [DATA_W-1:0]                  wdata_i,
    input  logic [NUM_VEC-1:0]                 en_i,
    input  logic [NUM_VEC-1:0]                 pend_i,
    input  logic [NUM_VEC/(GRP_W*4)*REG_W-1:0] route_i,
    output logic [NUM_VEC/GRP_W-1:0]           en_we_o,
    output logic [NUM_VEC/(GRP_W*4)-1:0]       rt_we_o,
    output logic [NUM_VEC-1:0]                 clr_o,
    output logic [DATA_W-1:0]                  rdata_o,
    output logic                               rd_valid_o
);

    localparam int EN_WORDS = NUM_VEC / GRP_W;
    localparam int RT_WORDS = NUM_VEC / (GRP_W * 4);
    localparam int ST_WORDS = NUM_VEC / STAT_W;
    localparam logic [ADDR_W-1:0] EN_SPAN = ADDR_W'(EN_WORDS * 4);
    localparam logic [ADDR_W-1:0] RT_SPAN = ADDR_W'(RT_WORDS * 4);
    localparam logic [ADDR_W-1:0] ST_SPAN = ADDR_W'(ST_WORDS * 8);

    logic [ADDR_W-1:0] en_off, rt_off, st_off;
    logic              hit_en, hit_rt, hit_st;
    logic [ADDR_W-3:0] en_idx, rt_idx;
    logic [ADDR_W-4:0] st_idx;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;
    bus_state_e        state_q, state_d;

    assign en_off = addr_i - EN_BASE;
    assign rt_off = addr_i - RT_BASE;
    assign st_off = addr_i - ST_BASE;
    assign hit_en = (en_off < EN_SPAN) && (en_off[1:0] == 2'b00);
    assign hit_rt = (rt_off < RT_SPAN) && (rt_off[1:0] == 2'b00);
    assign hit_st = (st_off < ST_SPAN) && (st_off[2:0] == 3'b000);
    assign en_idx = en_off[ADDR_W-1:2];
    assign rt_idx = rt_off[ADDR_W-1:2];
    assign st_idx = st_off[ADDR_W-1:3];

    for (genvar w = 0; w < EN_WORDS; w++) begin : g_en_we
        assign en_we_o[w] = wr_en_i && hit_en && (en_idx == (ADDR_W-2)'(w));
    end

    for (genvar w = 0; w < RT_WORDS; w++) begin : g_rt_we
        assign rt_we_o[w] = wr_en_i && hit_rt && (rt_idx == (ADDR_W-2)'(w));
    end

    for (genvar w = 0; w < ST_WORDS; w++) begin : g_clr
        assign clr_o[w*STAT_W +: STAT_W] =
            (wr_en_i && hit_st && (st_idx == (ADDR_W-3)'(w))) ? wdata_i : '0;
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < EN_WORDS; w++) begin
            if (hit_en && (en_idx == (ADDR_W-2)'(w))) begin
                rd_word = DATA_W'(en_i[w*GRP_W +: GRP_W]);
            end
        end
        for (int w = 0; w < RT_WORDS; w++) begin
            if (hit_rt && (rt_idx == (ADDR_W-2)'(w))) begin
                rd_word = DATA_W'(route_i[w*REG_W +: REG_W]);
            end
        end
        for (int w = 0; w < ST_WORDS; w++) begin
            if (hit_st && (st_idx == (ADDR_W-3)'(w))) begin
                rd_word = pend_i[w*STAT_W +: STAT_W];
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_en_i)  state_d = BUS_RESP;
            BUS_RESP: if (!rd_en_i) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            rdata_q <= rd_word;
        end
    end

    // Outputs
    always_comb begin
        rd_valid_o = (state_q == BUS_RESP);
        rdata_o    = rdata_q;
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o); // R11

    AST_RD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o); // R11

endmodule

// File: rtl/vec_pin_router.sv
module vec_pin_router
    import irqr_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int NUM_PIN = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_VEC-1:0]  irq_i,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                rd_valid_o,
    output logic [NUM_PIN-1:0]  pin_o
);

    localparam int EN_WORDS = NUM_VEC / GRP_W;
    localparam int RT_WORDS = NUM_VEC / (GRP_W * 4);

    logic [EN_WORDS-1:0]       en_we;
    logic [RT_WORDS-1:0]       rt_we;
    logic [NUM_VEC-1:0]        clr;
    logic [NUM_VEC-1:0]        pend;
    logic [NUM_VEC-1:0]        en;
    logic [RT_WORDS*REG_W-1:0] route;

    irqr_reg_port #(.NUM_VEC(NUM_VEC)) u_reg_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .en_i       (en),
        .pend_i     (pend),
        .route_i    (route),
        .en_we_o    (en_we),
        .rt_we_o    (rt_we),
        .clr_o      (clr),
        .rdata_o    (rdata_o),
        .rd_valid_o (rd_valid_o)
    );

    irqr_vec_state #(.NUM_VEC(NUM_VEC)) u_vec_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_i   (irq_i),
        .clr_i   (clr),
        .en_we_i (en_we),
        .wdata_i (wdata_i[REG_W-1:0]),
        .pend_o  (pend),
        .en_o    (en)
    );

    irqr_pin_route #(.NUM_VEC(NUM_VEC), .NUM_PIN(NUM_PIN)) u_pin_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .rt_we_i (rt_we),
        .wdata_i (wdata_i[REG_W-1:0]),
        .pend_i  (pend),
        .en_i    (en),
        .route_o (route),
        .pin_o   (pin_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_o == '0)); // R1

endmodule

// File: tb/vec_pin_router_bench.sv
module vec_pin_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 256;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NV-1:0] irq = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [7:0]    addr = '0;
    logic [63:0]   wdata = '0;
    logic [63:0]   rdata;
    logic          rd_valid;
    logic [NP-1:0] pin;

    int n_vec = 0;
    int n_bad = 0;

    logic [NV-1:0] m_pend = '0;
    logic [NV-1:0] m_en = '0;
    logic [7:0]    m_rt [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_pin_router #(.NUM_VEC(NV), .NUM_PIN(NP)) u_vec_pin_router (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .wr_en_i(wr), .rd_en_i(rd),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .rd_valid_o(rd_valid), .pin_o(pin)
    );

    function automatic logic [7:0] model_pins();
        logic [7:0] r = '0;
        for (int v = 0; v < NV; v++) begin
            if (m_pend[v] && m_en[v] && $countones(m_rt[v/32]) == 1) r |= m_rt[v/32];
        end
        return r;
    endfunction

    function automatic logic [63:0] model_read(input logic [7:0] a);
        int i;
        if (a < 8'h20 && a[1:0] == 2'b00) begin
            i = int'(a) / 4;
            return {32'h0, m_en[i*32 +: 32]};
        end
        if (a >= 8'h40 && a < 8'h48 && a[1:0] == 2'b00) begin
            i = (int'(a) - 64) / 4;
            return {32'h0, m_rt[i*4+3], m_rt[i*4+2], m_rt[i*4+1], m_rt[i*4]};
        end
        if (a >= 8'h80 && a < 8'hA0 && a[2:0] == 3'b000) begin
            i = (int'(a) - 128) / 8;
            return m_pend[i*64 +: 64];
        end
        return 64'h0;
    endfunction

    task automatic step(input string req);
        logic [7:0]    ep;
        logic [63:0]   er;
        logic          erv;
        logic [NV-1:0] clr;
        int            i;
        @(posedge clk);
        #2;
        ep  = model_pins();
        erv = rd;
        er  = rd ? model_read(addr) : 64'h0;
        clr = '0;
        if (wr) begin
            if (addr < 8'h20 && addr[1:0] == 2'b00) begin
                i = int'(addr) / 4;
                m_en[i*32 +: 32] = wdata[31:0];
            end else if (addr >= 8'h40 && addr < 8'h48 && addr[1:0] == 2'b00) begin
                i = (int'(addr) - 64) / 4;
                for (int b = 0; b < 4; b++) m_rt[i*4+b] = wdata[8*b +: 8];
            end else if (addr >= 8'h80 && addr < 8'hA0 && addr[2:0] == 3'b000) begin
                i = (int'(addr) - 128) / 8;
                clr[i*64 +: 64] = wdata;
            end
        end
        m_pend = (m_pend & ~clr) | irq;
        n_vec++;
        if (pin !== ep) begin
            n_bad++;
            $display("FAIL %s pin act=%h exp=%h", req, pin, ep);
        end
        if (rd_valid !== erv) begin
            n_bad++;
            $display("FAIL %s rd_valid act=%b exp=%b", req, rd_valid, erv);
        end else if (erv && rdata !== er) begin
            n_bad++;
            $display("FAIL %s rdata act=%h exp=%h", req, rdata, er);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [63:0] d, input string req);
        wr = 1'b1; addr = a; wdata = d;
        step(req);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        rd = 1'b1; addr = a;
        step(req);
        rd = 1'b0;
    endtask

    task automatic idle(input int n, input string req);
        for (int k = 0; k < n; k++) step(req);
    endtask

    task automatic pulse(input int v, input string req);
        irq[v] = 1'b1;
        step(req);
        irq[v] = 1'b0;
        idle(2, req);
    endtask

    task automatic clear_vec(input int v, input string req);
        do_write(8'(8'h80 + 8 * (v / 64)), 64'h1 << (v % 64), req);
        step(req);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int g = 0; g < 8; g++) m_rt[g] = 8'h00;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state at the ports
        n_vec++;
        if (pin !== '0 || rd_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset act=%h/%b exp=00/0", pin, rd_valid);
        end
        do_read(8'h00, "R1");
        do_read(8'h44, "R1");
        do_read(8'h98, "R1");

        // R5: enable word placement, upper data ignored
        for (int w = 0; w < 8; w++) do_write(8'(4 * w), 64'hFFFF_FFFF_FFFF_FFFF, "R5");
        do_write(8'h08, 64'hDEAD_BEEF_A5A5_0F0F, "R5");
        do_read(8'h08, "R5");
        do_read(8'h0C, "R5");
        do_write(8'h08, 64'hFFFF_FFFF, "R5");

        // R6 / R12: single-pin layout
        do_write(8'h40, 64'h0101_0101, "R6");
        do_write(8'h44, 64'h0101_0101, "R6");
        do_read(8'h44, "R6");
        pulse(200, "R12");
        clear_vec(200, "R12");

        // R12: multi-pin layout
        do_write(8'h40, 64'h0202_0101, "R12");
        do_write(8'h44, 64'h0808_0404, "R12");
        do_read(8'h40, "R6");
        pulse(10, "R12");  clear_vec(10, "R12");
        pulse(70, "R12");  clear_vec(70, "R12");
        pulse(130, "R12"); clear_vec(130, "R12");
        pulse(200, "R12"); clear_vec(200, "R12");

        // R2: level latch persists
        pulse(5, "R2");
        idle(3, "R2");
        do_read(8'h80, "R2");

        // R3: write-one-to-clear
        do_write(8'h80, 64'h0, "R3");
        do_read(8'h80, "R3");
        do_write(8'h80, 64'h20, "R3");
        do_read(8'h80, "R3");

        // R4: request beats clear
        irq[5] = 1'b1;
        do_write(8'h80, 64'h20, "R4");
        irq[5] = 1'b0;
        do_read(8'h80, "R4");
        clear_vec(5, "R4");

        // R8: disabled vector pends, drives nothing
        do_write(8'h04, 64'h0, "R8");
        pulse(40, "R8");
        do_read(8'h80, "R8");
        do_write(8'h04, 64'hFFFF_FFFF, "R8");
        idle(2, "R8");
        clear_vec(40, "R8");

        // R9: invalid route codes
        do_write(8'h40, 64'h0202_0100, "R9");
        pulse(3, "R9");
        do_read(8'h80, "R9");
        do_write(8'h40, 64'h0202_0103, "R9");
        idle(2, "R9");
        do_write(8'h40, 64'h0202_0104, "R9");
        idle(2, "R9");
        clear_vec(3, "R9");
        do_write(8'h40, 64'h0202_0101, "R9");

        // R10 / R7: status word layout, several pins at once
        irq[0] = 1'b1; irq[64] = 1'b1; irq[255] = 1'b1; irq[128] = 1'b1;
        step("R7");
        irq = '0;
        idle(2, "R7");
        do_read(8'h98, "R10");
        do_read(8'h90, "R10");
        do_read(8'h88, "R10");
        clear_vec(255, "R7");
        clear_vec(0, "R7");
        clear_vec(64, "R7");
        clear_vec(128, "R7");

        // R11: back-to-back reads
        rd = 1'b1;
        addr = 8'h40; step("R11");
        addr = 8'h44; step("R11");
        addr = 8'h1C; step("R11");
        rd = 1'b0;
        step("R11");

        // R13: unmapped addresses
        do_read(8'h60, "R13");
        do_read(8'h20, "R13");
        do_read(8'h48, "R13");
        do_write(8'h60, 64'h0, "R13");
        do_write(8'h20, 64'h0, "R13");
        do_read(8'h00, "R13");
        do_read(8'h1C, "R13");
        idle(2, "R13");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule